// File: doc/BRIEF.md
# DMA Channel Event Status Logic

This block follows one DMA channel through a frame and reports three kinds of event through status bits and interrupt requests. The first kind is progress: the channel has moved the first half of the frame. The second is an overrun: a new synchronization event came in while the previous request was still waiting for service or was being serviced. The third is a bus error: a timeout was flagged at the source port or at the destination port.

The channel's sequencer drives the inputs. It gives the frame length, a pulse at the start of each frame, a pulse for each completed element, the synchronization event input, a level that is high while a request is in service, and the two timeout flags. Software sets three interrupt enables. It reads the status word through a read strobe, and that read clears the word. The half-frame and drop bits share the channel interrupt line. The timeout bit has a bus-error line of its own.

Top module: `dma_evt_status`

## Requirements
- R1: The half-frame bit (`stat[2]`) becomes 1 only if `half_ie` was 1 in the cycle of the half-frame event. With `half_ie` at 0 the event leaves the bit unchanged.
- R2: For a frame of odd length N, the half-frame event happens on the element that makes the transferred count larger than the count still remaining. For N=5 this is the 3rd element, and for N=1 it is the 1st. A frame length of 0 never produces the event.
- R3: For a frame of even length N, the half-frame event happens on the element that brings the transferred count to N/2.
- R4: The half-frame event happens at most once per frame. A `frame_start` pulse zeroes the element count. If `elem_done` is high in the same cycle as `frame_start`, that element is counted as the first element of the new frame.
- R5: A drop event happens when `sync_evt` is high while `req_busy` is high, or while an earlier sync event is still pending. A sync event that is not dropped becomes pending. The pending state ends in any cycle in which `req_busy` is high.
- R6: The drop bit (`stat[1]`) becomes 1 only if `drop_ie` is 1 in the cycle of a drop event.
- R7: The timeout bit (`stat[0]`) becomes 1 when `tmo_ie` is 1 and either `src_tmo` or `dst_tmo` is 1.
- R8: `chan_irq` is a one-cycle pulse in the cycle in which `stat[2]` or `stat[1]` is newly set. `bus_err_irq` is a one-cycle pulse in the cycle in which `stat[0]` is newly set. A bit that is set in the same cycle as a read counts as newly set.
- R9: A `stat_rd` pulse clears all three status bits in the following cycle. If a bit is set in the same cycle as the read, the set wins.
- R10: After reset the status word is 0, both interrupt lines are 0, and no sync event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_len | input | CNT_W | Number of elements in the current frame |
| frame_start | input | 1 | Pulse at the start of a new frame |
| elem_done | input | 1 | Pulse for each element transferred |
| sync_evt | input | 1 | Synchronization event |
| req_busy | input | 1 | A request is in service |
| src_tmo | input | 1 | Source port timeout flag |
| dst_tmo | input | 1 | Destination port timeout flag |
| half_ie | input | 1 | Half-frame interrupt enable |
| drop_ie | input | 1 | Drop interrupt enable |
| tmo_ie | input | 1 | Timeout interrupt enable |
| stat_rd | input | 1 | Status read strobe, clears the status word |
| stat | output | 3 | Status word: bit 2 half-frame, bit 1 drop, bit 0 timeout |
| chan_irq | output | 1 | Channel interrupt pulse |
| bus_err_irq | output | 1 | Bus-error interrupt pulse |

## Verification
A wrong element count or a stale once-per-frame flag moves the half-frame bit one element early or late, or produces a second pulse in the same frame. This shows on `stat[2]` and `chan_irq` one clock after the element strobe concerned. A pending flag that is stuck high or stuck low turns the next sync event into a false drop, or lets a real drop through unseen. This shows on `stat[1]` one clock after that sync event. A bad clear or a bad priority between read and set loses or keeps a bit. This shows at the next sampled cycle after the read.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
    // Bit positions of the status word
    localparam int unsigned ST_HALF = 2;
    localparam int unsigned ST_DROP = 1;
    localparam int unsigned ST_TMO  = 0;
    localparam int unsigned ST_W    = 3;

    typedef struct packed {
        logic half;
        logic drop;
        logic tmo;
    } evt_t;
endpackage

// File: rtl/dma_half_det.sv
module dma_half_det #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] frame_len,
    input  logic             frame_start,
    input  logic             elem_done,
    output logic             half_evt
);
    localparam int unsigned CW = CNT_W + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fired;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] base_cnt;
    logic          base_fired;
    logic          step;
    logic [CW:0]   twice;

    always_comb begin
        st_d       = st_q;
        base_cnt   = frame_start ? '0 : st_q.cnt;
        base_fired = frame_start ? 1'b0 : st_q.fired;
        step       = elem_done && (base_cnt != {CW{1'b1}});
        st_d.cnt   = base_cnt + {{(CW-1){1'b0}}, step};
        twice      = {st_d.cnt, 1'b0};
        half_evt   = elem_done && !base_fired && (frame_len != '0)
                     && (twice >= {2'b00, frame_len});
        st_d.fired = base_fired | half_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_evt_on_elem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        half_evt |-> elem_done);
    p_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        half_evt |=> (!half_evt || frame_start));
endmodule

// File: rtl/dma_drop_det.sv
module dma_drop_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_evt,
    input  logic req_busy,
    output logic drop_evt
);
    typedef struct packed {
        logic pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        drop_evt = sync_evt && (st_q.pend || req_busy);
        if (req_busy)
            st_d.pend = 1'b0;
        else if (sync_evt && !drop_evt)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_drop_needs_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |-> sync_evt);
    p_busy_no_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_busy |=> !st_q.pend);
endmodule

// File: rtl/dma_stat_reg.sv
module dma_stat_reg
    import dma_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  evt_t            set,
    input  logic            rd,
    output logic [ST_W-1:0] stat,
    output logic            chan_irq,
    output logic            bus_err_irq
);
    typedef struct packed {
        evt_t bits;
        logic chan;
        logic bus;
    } st_t;

    st_t  st_d, st_q;
    evt_t fresh;
    evt_t kept;

    always_comb begin
        st_d       = st_q;
        kept       = rd ? '0 : st_q.bits;
        fresh      = set & ~kept;
        st_d.bits  = kept | set;
        st_d.chan  = fresh.half | fresh.drop;
        st_d.bus   = fresh.tmo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat        = st_q.bits;
    assign chan_irq    = st_q.chan;
    assign bus_err_irq = st_q.bus;

    p_chan_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chan_irq |-> (stat[ST_HALF] || stat[ST_DROP]));
    p_bus_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_irq |-> stat[ST_TMO]);
    p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && set == '0) |=> stat == '0);
endmodule

// File: rtl/dma_evt_status.sv
module dma_evt_status
    import dma_evt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] frame_len,
    input  logic             frame_start,
    input  logic             elem_done,
    input  logic             sync_evt,
    input  logic             req_busy,
    input  logic             src_tmo,
    input  logic             dst_tmo,
    input  logic             half_ie,
    input  logic             drop_ie,
    input  logic             tmo_ie,
    input  logic             stat_rd,
    output logic [2:0]       stat,
    output logic             chan_irq,
    output logic             bus_err_irq
);
    logic half_evt;
    logic drop_evt;
    evt_t set;

    dma_half_det #(.CNT_W(CNT_W)) u_half (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_len   (frame_len),
        .frame_start (frame_start),
        .elem_done   (elem_done),
        .half_evt    (half_evt)
    );

    dma_drop_det u_drop (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_evt (sync_evt),
        .req_busy (req_busy),
        .drop_evt (drop_evt)
    );

    always_comb begin
        set.half = half_evt && half_ie;
        set.drop = drop_evt && drop_ie;
        set.tmo  = (src_tmo || dst_tmo) && tmo_ie;
    end

    dma_stat_reg u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .set         (set),
        .rd          (stat_rd),
        .stat        (stat),
        .chan_irq    (chan_irq),
        .bus_err_irq (bus_err_irq)
    );

    p_half_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat[ST_HALF] && !half_ie) |=> !stat[ST_HALF]);
    p_drop_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat[ST_DROP] && !drop_ie) |=> !stat[ST_DROP]);
    p_tmo_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat[ST_TMO] && !(tmo_ie && (src_tmo || dst_tmo))) |=> !stat[ST_TMO]);
endmodule

// File: tb/tb_dma_evt_status.sv
module tb_dma_evt_status;
    localparam int unsigned CNT_W = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic [CNT_W-1:0] frame_len = '0;
    logic frame_start = 0, elem_done = 0, sync_evt = 0, req_busy = 0;
    logic src_tmo = 0, dst_tmo = 0, half_ie = 0, drop_ie = 0, tmo_ie = 0, stat_rd = 0;
    logic [2:0] stat;
    logic chan_irq, bus_err_irq;

    int total = 0, bad = 0;
    int m_cnt = 0;
    bit m_fired = 0, m_pend = 0;
    bit [2:0] m_stat = 0;
    bit m_chan = 0, m_bus = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_evt_status #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .frame_len(frame_len), .frame_start(frame_start),
        .elem_done(elem_done), .sync_evt(sync_evt), .req_busy(req_busy),
        .src_tmo(src_tmo), .dst_tmo(dst_tmo), .half_ie(half_ie), .drop_ie(drop_ie),
        .tmo_ie(tmo_ie), .stat_rd(stat_rd), .stat(stat), .chan_irq(chan_irq),
        .bus_err_irq(bus_err_irq)
    );

    function automatic bit half_point(int cnt, int len);
        return (len != 0) && (2 * cnt >= len);
    endfunction

    task automatic model_update();
        int cb; bit fb, hev, dev; bit [2:0] set, kept;
        cb = frame_start ? 0 : m_cnt;
        fb = frame_start ? 0 : m_fired;
        if (elem_done) cb = cb + 1;
        hev = elem_done && !fb && half_point(cb, int'(frame_len));
        m_cnt = cb;
        m_fired = fb | hev;
        dev = sync_evt && (m_pend || req_busy);
        if (req_busy) m_pend = 0;
        else if (sync_evt && !dev) m_pend = 1;
        set = {hev && half_ie, dev && drop_ie, (src_tmo || dst_tmo) && tmo_ie};
        kept = stat_rd ? 3'b000 : m_stat;
        m_chan = (set[2] && !kept[2]) || (set[1] && !kept[1]);
        m_bus = set[0] && !kept[0];
        m_stat = kept | set;
    endtask

    task automatic check(string tag);
        total++;
        if (stat !== m_stat || chan_irq !== m_chan || bus_err_irq !== m_bus) begin
            bad++;
            $display("FAIL %s: stat=%b chan=%b bus=%b expected stat=%b chan=%b bus=%b",
                     tag, stat, chan_irq, bus_err_irq, m_stat, m_chan, m_bus);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(tag);
        frame_start = 0; elem_done = 0; sync_evt = 0; stat_rd = 0;
        src_tmo = 0; dst_tmo = 0;
    endtask

    task automatic do_read(string tag);
        stat_rd = 1;
        step(tag);
    endtask

    // Runs a frame of len elements; expects the half bit on element hp
    task automatic run_frame(int len, int hp, string tag);
        frame_len = CNT_W'(len);
        frame_start = 1;
        step(tag);
        for (int i = 1; i <= len; i++) begin
            elem_done = 1;
            step(tag);
            total++;
            if ((i == hp) !== (chan_irq === 1'b1)) begin
                bad++;
                $display("FAIL %s: element %0d chan_irq=%b expected %b", tag, i, chan_irq, i == hp);
            end
        end
        do_read(tag);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R10: reset state
        total++;
        if (stat !== 3'b000 || chan_irq !== 0 || bus_err_irq !== 0) begin
            bad++;
            $display("FAIL R10: stat=%b chan=%b bus=%b expected 000 0 0", stat, chan_irq, bus_err_irq);
        end
        rst_n = 1;
        @(negedge clk);

        half_ie = 1;
        run_frame(5, 3, "R2 odd 5");
        run_frame(1, 1, "R2 odd 1");
        run_frame(7, 4, "R2 odd 7");
        run_frame(4, 2, "R3 even 4");
        run_frame(2, 1, "R3 even 2");
        run_frame(0, 0, "R2 zero length");
        half_ie = 0;
        run_frame(6, 0, "R1 enable off");
        total++;
        if (stat[2] !== 1'b0) begin
            bad++;
            $display("FAIL R1: stat[2]=%b expected 0", stat[2]);
        end
        half_ie = 1;

        // R4: restart mid-frame, start with element in same cycle
        frame_len = 16'd4;
        frame_start = 1; step("R4 start");
        elem_done = 1; step("R4 e1");
        frame_start = 1; elem_done = 1; step("R4 restart with element");
        elem_done = 1; step("R4 half after restart");
        total++;
        if (chan_irq !== 1'b1) begin
            bad++;
            $display("FAIL R4: chan_irq=%b expected 1", chan_irq);
        end
        do_read("R9 read");
        elem_done = 1; step("R4 no second event");
        elem_done = 1; step("R4 no second event");

        // R5 R6: drops
        drop_ie = 1;
        sync_evt = 1; step("R5 accept");
        sync_evt = 1; step("R5 drop while pending");
        do_read("R9 read");
        req_busy = 1; step("R5 service starts");
        sync_evt = 1; step("R5 drop while busy");
        req_busy = 0; do_read("R9 read");
        sync_evt = 1; step("R5 accept after service");
        req_busy = 1; step("R5 busy clears pending");
        req_busy = 0; sync_evt = 1; step("R5 no drop");
        drop_ie = 0;
        sync_evt = 1; step("R6 drop with enable off");
        do_read("R9 read");

        // R7 R8 R9: timeouts and read collision
        tmo_ie = 1;
        src_tmo = 1; step("R7 src timeout");
        dst_tmo = 1; step("R8 no pulse while set");
        dst_tmo = 1; stat_rd = 1; step("R9 set wins over read");
        do_read("R9 clear");
        tmo_ie = 0; src_tmo = 1; step("R7 enable off");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 40) == 0) begin
                frame_start = 1;
                frame_len = CNT_W'($urandom_range(0, 9));
            end
            elem_done = ($urandom_range(0, 2) == 0);
            sync_evt  = ($urandom_range(0, 4) == 0);
            req_busy  = ($urandom_range(0, 2) == 0);
            src_tmo   = ($urandom_range(0, 30) == 0);
            dst_tmo   = ($urandom_range(0, 30) == 0);
            stat_rd   = ($urandom_range(0, 5) == 0);
            half_ie   = ($urandom_range(0, 3) != 0);
            drop_ie   = ($urandom_range(0, 3) != 0);
            tmo_ie    = ($urandom_range(0, 3) != 0);
            step("R1-mix R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule